// File: doc/BRIEF.md
# Receive Frame Buffer Write Guard

This block holds the 128-byte receive frame buffer of a packet radio receiver and decides which radio-side writes may reach it. The receive datapath writes frame bytes through one write port. A host register interface reads the buffer and may also write it through a second port. When the host sets its safe-mode control bit and the transceiver is in one of the two listening states, an accepted frame locks the buffer. While the buffer is locked, later frames from the air cannot overwrite the stored frame. The host then has as much time as it needs to read the frame out.

What counts as an accepted frame depends on the operating mode. In basic mode a frame is accepted when its checksum is valid. In extended mode a frame is accepted when the receive-end interrupt is raised for it. A frame that starts while the buffer is locked is discarded whole, including its length byte. One cycle after the end of such a frame, a single-cycle dropped-frame pulse is raised. The lock is released in two ways: the host clears safe mode, or the transceiver leaves the listening states. The host can poll the lock state on a status output.

Top module: `rxbuf_guard`

## Requirements
- R1: Protection is enabled only while `safe_mode` is 1 and `trx_state` is listening: 2 (plain receive) or 3 (receive with auto-acknowledge). The other codes are 0 sleep, 1 idle and 4 transmit. When protection is disabled, no frame sets the lock.
- R2: In basic mode (`ext_mode`=0), a frame end with protection enabled sets the lock in the cycle after `rx_end` only if `rx_crc_ok` is 1. `rx_end_irq` is ignored.
- R3: In extended mode (`ext_mode`=1), a frame end with protection enabled sets the lock only if `rx_end_irq` is 1. `rx_crc_ok` is ignored.
- R4: While locked, a frame that starts (`rx_start`) writes none of its bytes into the buffer. The stored frame stays intact.
- R5: `frame_dropped` is 1 for exactly the one cycle after the `rx_end` of a frame that started while locked. It stays 0 for frames that were written.
- R6: Clearing `safe_mode` releases the lock on the next cycle. The next frame after release overwrites the buffer.
- R7: Host writes (`host_we`) update the buffer whether or not it is locked.
- R8: Moving `trx_state` to any non-listening code releases the lock on the next cycle, even if `safe_mode` stays 1.
- R9: If the host and the radio write the same address in the same cycle, the host data is stored.
- R10: When protection is disabled, each received frame overwrites the bytes of the previous frame.
- R11: A frame that starts while unlocked stores its bytes as they arrive, even if it then fails acceptance. In that case the buffer stays unlocked.
- R12: `locked` shows the current lock state. After reset `locked` and `frame_dropped` are 0.
- R13: A frame that started while locked stays discarded to its end, even if the lock is released partway through the frame. No byte of that frame is written, including the length byte at address 0.
- R14: `host_rdata` returns the byte at `host_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trx_state | input | 3 | Transceiver state code (0 sleep, 1 idle, 2 receive, 3 receive with auto-ack, 4 transmit) |
| ext_mode | input | 1 | 0 basic mode, 1 extended mode |
| safe_mode | input | 1 | Host safe-mode control bit |
| rx_start | input | 1 | Frame start strobe from the receive datapath |
| rx_we | input | 1 | Radio byte write strobe |
| rx_addr | input | 7 | Radio write address |
| rx_data | input | 8 | Radio write data |
| rx_end | input | 1 | Frame end strobe |
| rx_crc_ok | input | 1 | Checksum valid, qualified by `rx_end` |
| rx_end_irq | input | 1 | Receive-end interrupt raised, qualified by `rx_end` |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 7 | Host read/write address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle latency |
| locked | output | 1 | Lock status |
| frame_dropped | output | 1 | One-cycle pulse after a discarded frame ends |

## Verification
The bench sweeps every combination of the five state codes, both modes, safe mode, checksum flag and interrupt flag. For each combination it sends two frames with distinct data and computes the expected lock, drop pulse and buffer contents. This sweep separates the state gate, the per-mode choice of acceptance flag, a frame that fails acceptance but is still written, and plain overwriting. Directed sequences then cover:
- host writes while locked;
- a same-address collision between host and radio;
- release by clearing safe mode and by leaving the listening states;
- a locked frame whose lock is dropped partway through, which must stay discarded.

// File: rtl/rxbuf_guard_pkg.sv
package rxbuf_guard_pkg;

    typedef enum logic [2:0] {
        TRX_SLEEP  = 3'd0,
        TRX_IDLE   = 3'd1,
        TRX_RX     = 3'd2,
        TRX_RX_ACK = 3'd3,
        TRX_TX     = 3'd4
    } trx_state_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic       ext_mode;
        logic       crc_ok;
        logic       end_irq;
    } accept_info_t;

    function automatic logic is_listening(input logic [2:0] st);
        return (st == TRX_RX) || (st == TRX_RX_ACK);
    endfunction

    function automatic logic frame_accepted(input accept_info_t info);
        return info.ext_mode ? info.end_irq : info.crc_ok;
    endfunction

endpackage

// File: rtl/rxbuf_lock_ctrl.sv
module rxbuf_lock_ctrl
    import rxbuf_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] trx_state,
    input  logic       ext_mode,
    input  logic       safe_mode,
    input  logic       rx_end,
    input  logic       rx_crc_ok,
    input  logic       rx_end_irq,
    input  logic       frame_blk,
    output logic       locked
);
    lock_state_e  st_q, st_d;
    accept_info_t info;
    logic         prot_en;

    assign info    = '{ext_mode: ext_mode, crc_ok: rx_crc_ok, end_irq: rx_end_irq};
    assign prot_en = safe_mode && is_listening(trx_state);

    always_comb begin
        st_d = st_q;
        case (st_q)
            LK_OPEN: if (prot_en && rx_end && !frame_blk && frame_accepted(info)) st_d = LK_HELD;
            LK_HELD: if (!prot_en) st_d = LK_OPEN;
            default: st_d = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LK_OPEN;
        else     st_q <= st_d;
    end

    assign locked = (st_q == LK_HELD);

    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        !safe_mode |=> !locked);
    assert_leave_listen_R8: assert property (@(posedge clk) disable iff (rst)
        !is_listening(trx_state) |=> !locked);
    assert_lock_on_end_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(rx_end && !frame_blk && safe_mode));
    assert_mode_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!locked && rx_end && ext_mode && !rx_end_irq) |=> !locked);

endmodule

// File: rtl/rxbuf_frame_track.sv
module rxbuf_frame_track (
    input  logic clk,
    input  logic rst,
    input  logic rx_start,
    input  logic rx_end,
    input  logic locked,
    output logic frame_blk,
    output logic frame_dropped
);
    logic disc_q;

    // a frame's verdict is taken at its start and held until its end
    assign frame_blk = rx_start ? locked : disc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            disc_q        <= 1'b0;
            frame_dropped <= 1'b0;
        end else begin
            if (rx_start)    disc_q <= locked;
            else if (rx_end) disc_q <= 1'b0;
            frame_dropped <= rx_end && frame_blk;
        end
    end

    assert_drop_after_end_R5: assert property (@(posedge clk) disable iff (rst)
        frame_dropped |-> $past(rx_end));
    assert_held_discard_R13: assert property (@(posedge clk) disable iff (rst)
        (disc_q && !rx_end && !rx_start) |=> disc_q);

endmodule

// File: rtl/rxbuf_mem.sv
module rxbuf_mem #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rad_we,
    input  logic [AW-1:0] rad_addr,
    input  logic [DW-1:0] rad_data,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rad_we && !(host_we && host_addr == rad_addr)) mem[rad_addr] <= rad_data;
        if (host_we) mem[host_addr] <= host_wdata;
        host_rdata <= mem[host_addr];
    end

endmodule

// File: rtl/rxbuf_guard.sv
module rxbuf_guard
    import rxbuf_guard_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    trx_state,
    input  logic          ext_mode,
    input  logic          safe_mode,
    input  logic          rx_start,
    input  logic          rx_we,
    input  logic [AW-1:0] rx_addr,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_end,
    input  logic          rx_crc_ok,
    input  logic          rx_end_irq,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          locked,
    output logic          frame_dropped
);
    logic frame_blk;
    logic rad_ok;

    rxbuf_lock_ctrl u_lock (
        .clk(clk), .rst(rst), .trx_state(trx_state), .ext_mode(ext_mode),
        .safe_mode(safe_mode), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
        .rx_end_irq(rx_end_irq), .frame_blk(frame_blk), .locked(locked)
    );

    rxbuf_frame_track u_track (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_end(rx_end),
        .locked(locked), .frame_blk(frame_blk), .frame_dropped(frame_dropped)
    );

    assign rad_ok = rx_we && !frame_blk;

    rxbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk(clk), .rad_we(rad_ok), .rad_addr(rx_addr), .rad_data(rx_data),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    assert_locked_start_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (locked && rx_start) |-> !rad_ok);
    assert_no_lock_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        (!locked && !(safe_mode && is_listening(trx_state))) |=> !locked);

endmodule

// File: tb/rxbuf_guard_bench.sv
module rxbuf_guard_bench;
    import rxbuf_guard_pkg::*;

    localparam int NB = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] trx_state;
    logic       ext_mode, safe_mode, rx_start, rx_we, rx_end, rx_crc_ok, rx_end_irq;
    logic [6:0] rx_addr, host_addr;
    logic [7:0] rx_data, host_wdata, host_rdata;
    logic       host_we, locked, frame_dropped;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rxbuf_guard u_rxbuf_guard (
        .clk(clk), .rst(rst), .trx_state(trx_state), .ext_mode(ext_mode),
        .safe_mode(safe_mode), .rx_start(rx_start), .rx_we(rx_we), .rx_addr(rx_addr),
        .rx_data(rx_data), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .rx_end_irq(rx_end_irq),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .locked(locked), .frame_dropped(frame_dropped)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] base, input bit crc, input bit irq, input bit release_mid);
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        for (int i = 0; i < NB; i++) begin
            rx_we = 1'b1; rx_addr = 7'(i); rx_data = base + 8'(i);
            if (release_mid && i == 1) safe_mode = 1'b0;
            @(negedge clk);
        end
        rx_we = 1'b0; rx_end = 1'b1; rx_crc_ok = crc; rx_end_irq = irq;
        @(negedge clk);
        rx_end = 1'b0; rx_crc_ok = 1'b0; rx_end_irq = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a;
        @(negedge clk); d = host_rdata;
    endtask

    task automatic quiesce();
        @(negedge clk); trx_state = TRX_IDLE; safe_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_buf(input logic [7:0] base, input string req);
        logic [7:0] d;
        for (int i = 0; i < NB; i++) begin
            rd(7'(i), d);
            check(d == base + 8'(i), req, d, base + 8'(i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; trx_state = TRX_IDLE; ext_mode = 1'b0; safe_mode = 1'b0;
        rx_start = 1'b0; rx_we = 1'b0; rx_addr = '0; rx_data = '0; rx_end = 1'b0;
        rx_crc_ok = 1'b0; rx_end_irq = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(locked == 1'b0, "R12 reset locked", locked, 0);
        check(frame_dropped == 1'b0, "R12 reset drop", frame_dropped, 0);

        // Sweep: state x mode x safe x crc x irq (R1 R2 R3 R4 R5 R10 R11)
        for (int st = 0; st < 5; st++)
          for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++)
              for (int c = 0; c < 2; c++)
                for (int q = 0; q < 2; q++) begin
                    automatic bit en   = s && (st == 2 || st == 3);
                    automatic bit acc  = m ? q : c;
                    automatic bit lk   = en && acc;
                    automatic logic [7:0] ba = 8'(st*40 + m*20 + s*10 + c*4 + q*2 + 1);
                    automatic logic [7:0] bb = ba ^ 8'h80;
                    quiesce();
                    @(negedge clk); trx_state = 3'(st); ext_mode = m[0]; safe_mode = s[0];
                    frame(ba, c[0], q[0], 1'b0);
                    check(locked == lk, m ? "R3 lock after first frame" : "R2 lock after first frame", locked, lk);
                    check(frame_dropped == 1'b0, "R5 no drop on written frame", frame_dropped, 0);
                    frame(bb, c[0], q[0], 1'b0);
                    check(frame_dropped == lk, "R5 drop pulse for blocked frame", frame_dropped, lk);
                    @(negedge clk);
                    check(frame_dropped == 1'b0, "R5 drop lasts one cycle", frame_dropped, 0);
                    check(locked == lk, "R12 lock status held", locked, lk);
                    if (!en) check(locked == 1'b0, "R1 disabled never locks", locked, 0);
                    // R4 blocked frame leaves A; R10/R11 otherwise B overwrites; R14 read latency
                    expect_buf(lk ? ba : bb, lk ? "R4 buffer kept" : (en ? "R11 unaccepted frame stored" : "R10 overwrite"));
                end

        // R7 host write while locked
        quiesce();
        @(negedge clk); trx_state = TRX_RX; ext_mode = 1'b0; safe_mode = 1'b1;
        frame(8'h10, 1'b1, 1'b0, 1'b0);
        check(locked == 1'b1, "R2 locked before host write", locked, 1);
        @(negedge clk); host_we = 1'b1; host_addr = 7'd1; host_wdata = 8'hA5;
        @(negedge clk); host_we = 1'b0;
        rd(7'd1, d);
        check(d == 8'hA5, "R7 host write while locked", d, 8'hA5);

        // R13 lock released mid-frame: frame still discarded, drop pulse raised
        frame(8'h60, 1'b1, 1'b0, 1'b1);
        check(frame_dropped == 1'b1, "R13 drop after mid-frame release", frame_dropped, 1);
        check(locked == 1'b0, "R6 released by safe clear", locked, 0);
        rd(7'd0, d);
        check(d == 8'h10, "R13 length byte not written", d, 8'h10);
        rd(7'd2, d);
        check(d == 8'h12, "R13 later byte not written", d, 8'h12);

        // R6 after release the next frame overwrites
        frame(8'h70, 1'b1, 1'b0, 1'b0);
        check(frame_dropped == 1'b0, "R6 frame after release written", frame_dropped, 0);
        expect_buf(8'h70, "R6 overwrite after release");

        // R8 leaving listening state releases lock with safe still set
        @(negedge clk); safe_mode = 1'b1; trx_state = TRX_RX_ACK; ext_mode = 1'b1;
        frame(8'h30, 1'b0, 1'b1, 1'b0);
        check(locked == 1'b1, "R3 locked in ack-listen", locked, 1);
        @(negedge clk); trx_state = TRX_TX;
        @(negedge clk); trx_state = TRX_RX_ACK;
        check(locked == 1'b0, "R8 released by leaving listen", locked, 0);
        frame(8'h90, 1'b0, 1'b0, 1'b0);
        expect_buf(8'h90, "R8 overwrite after leave");

        // R9 same-address collision: host wins; other radio byte still stored
        quiesce();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        rx_we = 1'b1; rx_addr = 7'd5; rx_data = 8'h11;
        host_we = 1'b1; host_addr = 7'd5; host_wdata = 8'h22;
        @(negedge clk); host_we = 1'b0; rx_addr = 7'd6; rx_data = 8'h33;
        @(negedge clk); rx_we = 1'b0; rx_end = 1'b1;
        @(negedge clk); rx_end = 1'b0;
        rd(7'd5, d);
        check(d == 8'h22, "R9 host wins collision", d, 8'h22);
        rd(7'd6, d);
        check(d == 8'h33, "R9 radio byte elsewhere", d, 8'h33);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule